// File: doc/BRIEF.md
# Processor Status Word Unit

This block keeps the 16-bit status word of a processor core. The low byte carries the five condition flags (extend, negative, zero, overflow, carry). The high byte carries the trace flag, the supervisor flag and a three-bit interrupt priority mask. The unit carries out one operation per strobe: read the whole word, load the whole word, load only the flag byte, or combine an immediate with either the flag byte or the whole word through OR, AND or XOR. Every result, pulse and cycle cost is registered and appears one clock after the strobe.

The unit also holds the two stack pointers of the core. One is the pointer in use and the other is the saved pointer of the other privilege mode. When an operation flips the supervisor flag, the two pointers trade places on the same clock edge. The unit also pulses requests telling the sequencer to re-evaluate pending interrupts or the trace condition. A whole-word write attempted while the core runs in user mode is refused: the unit reports a privilege fault with exception vector 8 and leaves its state untouched.

Top module: `stat_word_unit`

## Requirements
- R1: After reset the status word is 0x2000 (supervisor flag set, all other bits clear), both stack pointers are 0, and every pulse output is low.
- R2: A read (`op_code`=0) loads `rd_data` with the status word. It is allowed in either mode and reports a cost of 6 cycles, or 8 when `rd_to_mem`=1.
- R3: A whole-word load (`op_code`=1) in supervisor mode stores `op_operand[15:8]` ANDed with 0xA7 (or 0x27 when `TRACE_EN`=0) as the high byte and `op_operand[4:0]` as the flags, with word bits 7..5 held at zero. It costs 12 cycles and raises both recheck pulses.
- R4: A whole-word load or whole-word logic op with `cpu_super`=0 raises `priv_fault` with `fault_vector`=8 and a cost of 34. The status word and the stack pointers stay unchanged and no other pulse is raised.
- R5: A flag-byte load (`op_code`=2) replaces bits 4..0 with `op_operand[4:0]` in either mode. The high byte is kept, the cost is 12 and no recheck is raised.
- R6: A flag-byte logic op (`op_code`=3) combines bits 4..0 with `op_operand[4:0]` using `op_fn` (0=OR, 1=AND, 2=XOR) in either mode. The high byte is kept, the cost is 16 and no recheck is raised.
- R7: A whole-word logic op (`op_code`=4) combines both bytes with the operand using `op_fn` and then applies the same high-byte mask as R3. The cost is 16.
- R8: On a whole-word logic op, `irq_recheck` pulses only for AND and XOR, and `trace_recheck` pulses only for OR and XOR.
- R9: When an operation changes status bit 13 (supervisor), `sp_swap` pulses and `live_sp` and `shadow_sp` exchange values on that same edge. No swap happens when bit 13 keeps its value.
- R10: `op_fn`=3 with `op_code` 3 or 4, or any `op_code` of 5..7, raises `op_illegal` with cost 0 and changes nothing. This check takes precedence over the privilege check.
- R11: With `op_valid` low, `sp_load` writes `sp_load_val` into `live_sp` (`sp_load_sel`=0) or `shadow_sp` (`sp_load_sel`=1). With `op_valid` high, `sp_load` is ignored.
- R12: `op_done` is high in exactly the cycle after each strobe, and low after a cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | One-cycle operation strobe |
| op_code | input | 3 | Operation: 0 read, 1 word load, 2 flag load, 3 flag logic, 4 word logic |
| op_fn | input | 2 | Logic function: 0 OR, 1 AND, 2 XOR, 3 reserved |
| op_operand | input | 16 | Immediate or load value |
| cpu_super | input | 1 | Core privilege mode used for the privilege check |
| rd_to_mem | input | 1 | Read destination is memory (selects the cost) |
| sp_load | input | 1 | Stack pointer load request |
| sp_load_sel | input | 1 | 0 selects the live pointer, 1 the shadow pointer |
| sp_load_val | input | SP_W | Value to load |
| status_word | output | 16 | Current status word |
| rd_data | output | 16 | Word captured by the last read |
| op_done | output | 1 | Operation completed |
| op_cost | output | COST_W | Cycle cost of the completed operation |
| op_illegal | output | 1 | Reserved encoding rejected |
| priv_fault | output | 1 | Privilege violation |
| fault_vector | output | VEC_W | Exception vector of the fault (8), else 0 |
| sp_swap | output | 1 | Stack pointers exchanged |
| irq_recheck | output | 1 | Interrupts must be re-evaluated |
| trace_recheck | output | 1 | Trace condition must be re-evaluated |
| live_sp | output | SP_W | Stack pointer in use |
| shadow_sp | output | SP_W | Stack pointer of the other mode |

## Verification
The bench walks a chain of operations in which each step starts from the word the previous step left. The chain crosses the supervisor flag in both directions and leaves it alone in between, so a design that keys the swap on the operation type rather than on an actual flag change would swap pointers at the wrong times. Refused whole-word writes in user mode, reserved function codes and unused opcodes are interleaved with legal ones; a design that let any of them touch the word or report the wrong precedence would corrupt every later expectation. A second instance with trace support disabled receives the same stimulus, so a wrong or missing high-byte mask shows up as a stray trace bit. Pointer loads issued together with a strobe show whether a design lets the load beat the operation.

// File: rtl/stat_word_pkg.sv
package stat_word_pkg;

   localparam int WORD_W = 16;
   localparam int S_BIT  = 13;
   localparam int T_BIT  = 15;

   localparam logic [2:0] OPC_READ     = 3'd0;
   localparam logic [2:0] OPC_WR_WORD  = 3'd1;
   localparam logic [2:0] OPC_WR_CC    = 3'd2;
   localparam logic [2:0] OPC_LOG_CC   = 3'd3;
   localparam logic [2:0] OPC_LOG_WORD = 3'd4;

   typedef enum logic [1:0] {
      FN_OR   = 2'd0,
      FN_AND  = 2'd1,
      FN_XOR  = 2'd2,
      FN_RSVD = 2'd3
   } logic_fn_e;

   localparam logic [7:0] CC_KEEP = 8'h1F;

   function automatic logic [7:0] hi_keep(input bit trace_en);
      return trace_en ? 8'hA7 : 8'h27;
   endfunction

   typedef struct packed {
      logic illegal;
      logic priv;
      logic is_read;
      logic wr_hi;
      logic wr_lo;
      logic use_logic;
      logic irq_chk;
      logic trace_chk;
   } dec_t;

endpackage

// File: rtl/stat_op_decode.sv
module stat_op_decode
   import stat_word_pkg::*;
#(
   parameter int COST_W     = 8,
   parameter int CYC_RD_REG = 6,
   parameter int CYC_RD_MEM = 8,
   parameter int CYC_WR     = 12,
   parameter int CYC_LOGIC  = 16,
   parameter int CYC_PRIV   = 34
) (
   input  logic [2:0]        op_code,
   input  logic_fn_e         op_fn,
   input  logic              cpu_super,
   input  logic              rd_to_mem,
   output dec_t              dec,
   output logic [COST_W-1:0] cost
);

   logic fn_bad;
   assign fn_bad = (op_fn == FN_RSVD);

   always_comb begin
      dec  = '0;
      cost = '0;
      case (op_code)
         OPC_READ: begin
            dec.is_read = 1'b1;
            cost = rd_to_mem ? COST_W'(CYC_RD_MEM) : COST_W'(CYC_RD_REG);
         end
         OPC_WR_CC: begin
            dec.wr_lo = 1'b1;
            cost = COST_W'(CYC_WR);
         end
         OPC_LOG_CC: begin
            if (fn_bad) begin
               dec.illegal = 1'b1;
            end else begin
               dec.wr_lo     = 1'b1;
               dec.use_logic = 1'b1;
               cost = COST_W'(CYC_LOGIC);
            end
         end
         OPC_WR_WORD: begin
            if (!cpu_super) begin
               dec.priv = 1'b1;
               cost = COST_W'(CYC_PRIV);
            end else begin
               dec.wr_hi     = 1'b1;
               dec.wr_lo     = 1'b1;
               dec.irq_chk   = 1'b1;
               dec.trace_chk = 1'b1;
               cost = COST_W'(CYC_WR);
            end
         end
         OPC_LOG_WORD: begin
            if (fn_bad) begin
               dec.illegal = 1'b1;
            end else if (!cpu_super) begin
               dec.priv = 1'b1;
               cost = COST_W'(CYC_PRIV);
            end else begin
               dec.wr_hi     = 1'b1;
               dec.wr_lo     = 1'b1;
               dec.use_logic = 1'b1;
               dec.irq_chk   = (op_fn != FN_OR);
               dec.trace_chk = (op_fn != FN_AND);
               cost = COST_W'(CYC_LOGIC);
            end
         end
         default: dec.illegal = 1'b1;
      endcase
   end

endmodule

// File: rtl/stat_logic_unit.sv
module stat_logic_unit
   import stat_word_pkg::*;
#(
   parameter bit TRACE_EN = 1'b1
) (
   input  logic [WORD_W-1:0] cur,
   input  logic [WORD_W-1:0] operand,
   input  logic_fn_e         op_fn,
   input  logic              use_logic,
   input  logic              wr_hi,
   input  logic              wr_lo,
   output logic [WORD_W-1:0] nxt
);

   logic [7:0]        keep_hi;
   logic [WORD_W-1:0] raw;
   logic [WORD_W-1:0] src;

   generate
      if (TRACE_EN) begin : g_trace
         assign keep_hi = 8'hA7;
      end else begin : g_notrace
         assign keep_hi = 8'h27;
      end
   endgenerate

   always_comb begin
      case (op_fn)
         FN_OR:   raw = cur | operand;
         FN_AND:  raw = cur & operand;
         FN_XOR:  raw = cur ^ operand;
         default: raw = cur;
      endcase
   end

   assign src = use_logic ? raw : operand;

   assign nxt[15:8] = wr_hi ? (src[15:8] & keep_hi) : cur[15:8];
   assign nxt[7:0]  = wr_lo ? (src[7:0]  & CC_KEEP) : cur[7:0];

endmodule

// File: rtl/stat_sp_bank.sv
module stat_sp_bank #(
   parameter int SP_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            swap,
   input  logic            load_en,
   input  logic            load_sel,
   input  logic [SP_W-1:0] load_val,
   output logic [SP_W-1:0] live_sp,
   output logic [SP_W-1:0] shadow_sp
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_sp   <= '0;
         shadow_sp <= '0;
      end else if (swap) begin
         live_sp   <= shadow_sp;
         shadow_sp <= live_sp;
      end else if (load_en) begin
         if (load_sel) shadow_sp <= load_val;
         else          live_sp   <= load_val;
      end
   end

endmodule

// File: rtl/stat_word_unit.sv
module stat_word_unit
   import stat_word_pkg::*;
#(
   parameter bit TRACE_EN    = 1'b1,
   parameter int SP_W        = 32,
   parameter int COST_W      = 8,
   parameter int VEC_W       = 8,
   parameter int PRIV_VECTOR = 8,
   parameter int CYC_RD_REG  = 6,
   parameter int CYC_RD_MEM  = 8,
   parameter int CYC_WR      = 12,
   parameter int CYC_LOGIC   = 16,
   parameter int CYC_PRIV    = 34
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [1:0]        op_fn,
   input  logic [15:0]       op_operand,
   input  logic              cpu_super,
   input  logic              rd_to_mem,
   input  logic              sp_load,
   input  logic              sp_load_sel,
   input  logic [SP_W-1:0]   sp_load_val,
   output logic [15:0]       status_word,
   output logic [15:0]       rd_data,
   output logic              op_done,
   output logic [COST_W-1:0] op_cost,
   output logic              op_illegal,
   output logic              priv_fault,
   output logic [VEC_W-1:0]  fault_vector,
   output logic              sp_swap,
   output logic              irq_recheck,
   output logic              trace_recheck,
   output logic [SP_W-1:0]   live_sp,
   output logic [SP_W-1:0]   shadow_sp
);

   localparam logic [15:0] RST_WORD = 16'h0001 << S_BIT;
   localparam logic [15:0] KEEP_ALL = {hi_keep(TRACE_EN), CC_KEEP};
   localparam int          MAX_CYC  = (CYC_PRIV > CYC_LOGIC) ? CYC_PRIV : CYC_LOGIC;

   generate
      if (SP_W < 1) begin : g_bad_sp
         $error("stat_word_unit: SP_W must be at least 1");
      end
      if (COST_W < $clog2(MAX_CYC + 1)) begin : g_bad_cost
         $error("stat_word_unit: COST_W too narrow for the cycle costs");
      end
      if (VEC_W < $clog2(PRIV_VECTOR + 1)) begin : g_bad_vec
         $error("stat_word_unit: VEC_W too narrow for the fault vector");
      end
   endgenerate

   dec_t              dec;
   logic [COST_W-1:0] cost;
   logic [15:0]       stat_q;
   logic [15:0]       stat_nxt;
   logic              flip_s;

   stat_op_decode #(
      .COST_W     (COST_W),
      .CYC_RD_REG (CYC_RD_REG),
      .CYC_RD_MEM (CYC_RD_MEM),
      .CYC_WR     (CYC_WR),
      .CYC_LOGIC  (CYC_LOGIC),
      .CYC_PRIV   (CYC_PRIV)
   ) u_dec (
      .op_code   (op_code),
      .op_fn     (logic_fn_e'(op_fn)),
      .cpu_super (cpu_super),
      .rd_to_mem (rd_to_mem),
      .dec       (dec),
      .cost      (cost)
   );

   stat_logic_unit #(
      .TRACE_EN (TRACE_EN)
   ) u_alu (
      .cur       (stat_q),
      .operand   (op_operand),
      .op_fn     (logic_fn_e'(op_fn)),
      .use_logic (dec.use_logic),
      .wr_hi     (dec.wr_hi),
      .wr_lo     (dec.wr_lo),
      .nxt       (stat_nxt)
   );

   assign flip_s = op_valid && (stat_nxt[S_BIT] != stat_q[S_BIT]);

   stat_sp_bank #(
      .SP_W (SP_W)
   ) u_sp (
      .clk       (clk),
      .rst_n     (rst_n),
      .swap      (flip_s),
      .load_en   (sp_load && !op_valid),
      .load_sel  (sp_load_sel),
      .load_val  (sp_load_val),
      .live_sp   (live_sp),
      .shadow_sp (shadow_sp)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q        <= RST_WORD;
         rd_data       <= '0;
         op_done       <= 1'b0;
         op_cost       <= '0;
         op_illegal    <= 1'b0;
         priv_fault    <= 1'b0;
         fault_vector  <= '0;
         sp_swap       <= 1'b0;
         irq_recheck   <= 1'b0;
         trace_recheck <= 1'b0;
      end else begin
         op_done       <= op_valid;
         op_cost       <= op_valid ? cost : '0;
         op_illegal    <= op_valid && dec.illegal;
         priv_fault    <= op_valid && dec.priv;
         fault_vector  <= (op_valid && dec.priv) ? VEC_W'(PRIV_VECTOR) : '0;
         sp_swap       <= flip_s;
         irq_recheck   <= op_valid && dec.irq_chk;
         trace_recheck <= op_valid && dec.trace_chk;
         if (op_valid) begin
            stat_q <= stat_nxt;
            if (dec.is_read) rd_data <= stat_q;
         end
      end
   end

   assign status_word = stat_q;

   // Undefined bits never become visible (R3)
   assert_resv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (status_word & ~KEEP_ALL) == 16'h0000);

   // User-mode whole-word load is refused and leaves state alone (R4)
   assert_priv_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OPC_WR_WORD && !cpu_super)
      |=> (priv_fault && !sp_swap && status_word == $past(status_word)));

   // OR on the whole word never asks for an interrupt recheck (R8)
   assert_or_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OPC_LOG_WORD && op_fn == 2'd0) |=> !irq_recheck);

   // AND on the whole word never asks for a trace recheck (R8)
   assert_and_no_trace_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OPC_LOG_WORD && op_fn == 2'd1) |=> !trace_recheck);

   // A swap pulse comes with exchanged pointers and a flipped supervisor bit (R9)
   assert_swap_xchg_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sp_swap |-> (live_sp == $past(shadow_sp) && shadow_sp == $past(live_sp)
                   && status_word[S_BIT] != $past(status_word[S_BIT])));

   // Unused opcodes are rejected and change nothing (R10)
   assert_illegal_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code > OPC_LOG_WORD)
      |=> (op_illegal && !priv_fault && $stable(status_word)));

   // Completion pulse follows every strobe and only a strobe (R12)
   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |=> op_done);
   assert_done_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !op_done);

endmodule

// File: tb/sim_stat_word_unit.sv
module sim_stat_word_unit;

   localparam int SP_W = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            op_valid = 1'b0;
   logic [2:0]      op_code = '0;
   logic [1:0]      op_fn = '0;
   logic [15:0]     op_operand = '0;
   logic            cpu_super = 1'b0;
   logic            rd_to_mem = 1'b0;
   logic            sp_load = 1'b0;
   logic            sp_load_sel = 1'b0;
   logic [SP_W-1:0] sp_load_val = '0;

   logic [15:0]     status_word, rd_data, status_nt, rd_nt;
   logic            op_done, op_illegal, priv_fault, sp_swap, irq_recheck, trace_recheck;
   logic [7:0]      op_cost, fault_vector;
   logic [SP_W-1:0] live_sp, shadow_sp;
   logic            done_nt, ill_nt, priv_nt, swap_nt, irq_nt, trc_nt;
   logic [7:0]      cost_nt, vec_nt;
   logic [SP_W-1:0] live_nt, shadow_nt;

   always #2 clk = ~clk;

   stat_word_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_fn(op_fn),
      .op_operand(op_operand), .cpu_super(cpu_super), .rd_to_mem(rd_to_mem),
      .sp_load(sp_load), .sp_load_sel(sp_load_sel), .sp_load_val(sp_load_val),
      .status_word(status_word), .rd_data(rd_data), .op_done(op_done), .op_cost(op_cost),
      .op_illegal(op_illegal), .priv_fault(priv_fault), .fault_vector(fault_vector),
      .sp_swap(sp_swap), .irq_recheck(irq_recheck), .trace_recheck(trace_recheck),
      .live_sp(live_sp), .shadow_sp(shadow_sp)
   );

   stat_word_unit #(.TRACE_EN(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_fn(op_fn),
      .op_operand(op_operand), .cpu_super(cpu_super), .rd_to_mem(rd_to_mem),
      .sp_load(sp_load), .sp_load_sel(sp_load_sel), .sp_load_val(sp_load_val),
      .status_word(status_nt), .rd_data(rd_nt), .op_done(done_nt), .op_cost(cost_nt),
      .op_illegal(ill_nt), .priv_fault(priv_nt), .fault_vector(vec_nt),
      .sp_swap(swap_nt), .irq_recheck(irq_nt), .trace_recheck(trc_nt),
      .live_sp(live_nt), .shadow_sp(shadow_nt)
   );

   // {opcode, fn, super, to_mem, operand, expected word, expected cost,
   //  expected {illegal, priv, swap, irq_recheck, trace_recheck}}
   localparam int NV = 17;
   localparam logic [51:0] VEC [NV] = '{
      {3'd0, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h2000, 8'd6,  5'b00000},
      {3'd2, 2'd0, 1'b0, 1'b0, 16'h00FF, 16'h201F, 8'd12, 5'b00000},
      {3'd3, 2'd1, 1'b0, 1'b0, 16'h0015, 16'h2015, 8'd16, 5'b00000},
      {3'd3, 2'd2, 1'b0, 1'b0, 16'h000F, 16'h201A, 8'd16, 5'b00000},
      {3'd3, 2'd0, 1'b0, 1'b0, 16'h0001, 16'h201B, 8'd16, 5'b00000},
      {3'd1, 2'd0, 1'b0, 1'b0, 16'h0000, 16'h201B, 8'd34, 5'b01000},
      {3'd4, 2'd0, 1'b0, 1'b0, 16'h0700, 16'h201B, 8'd34, 5'b01000},
      {3'd4, 2'd0, 1'b1, 1'b0, 16'h0700, 16'h271B, 8'd16, 5'b00001},
      {3'd4, 2'd1, 1'b1, 1'b0, 16'hFBFF, 16'h231B, 8'd16, 5'b00010},
      {3'd4, 2'd2, 1'b1, 1'b0, 16'hA000, 16'h831B, 8'd16, 5'b00111},
      {3'd4, 2'd3, 1'b1, 1'b0, 16'hFFFF, 16'h831B, 8'd0,  5'b10000},
      {3'd5, 2'd0, 1'b1, 1'b0, 16'hFFFF, 16'h831B, 8'd0,  5'b10000},
      {3'd1, 2'd0, 1'b1, 1'b0, 16'hFFFF, 16'hA71F, 8'd12, 5'b00111},
      {3'd0, 2'd0, 1'b0, 1'b1, 16'h0000, 16'hA71F, 8'd8,  5'b00000},
      {3'd1, 2'd0, 1'b1, 1'b0, 16'h2700, 16'h2700, 8'd12, 5'b00011},
      {3'd3, 2'd0, 1'b0, 1'b0, 16'hFF00, 16'h2700, 8'd16, 5'b00000},
      {3'd1, 2'd0, 1'b1, 1'b0, 16'h00E0, 16'h0000, 8'd12, 5'b00111}
   };

   int  n_chk = 0;
   int  n_bad = 0;
   bit  ended = 1'b0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input logic [2:0] opc, input logic [4:0] fl);
      if (fl[4])          return "R10";
      if (fl[3])          return "R4";
      case (opc)
         3'd0:    return "R2";
         3'd1:    return "R3";
         3'd2:    return "R5";
         3'd3:    return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
      finish_run();
   end

   initial begin
      logic [SP_W-1:0] m_live, m_shadow;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(status_word == 16'h2000, "R1", "reset word", 32'(status_word), 32'h2000);
      chk(live_sp == '0 && shadow_sp == '0, "R1", "reset pointers", live_sp | shadow_sp, 0);
      chk({op_done, op_illegal, priv_fault, sp_swap, irq_recheck, trace_recheck} == '0,
          "R1", "reset pulses",
          32'({op_done, op_illegal, priv_fault, sp_swap, irq_recheck, trace_recheck}), 0);

      // R11: pointer loads while idle
      sp_load = 1'b1; sp_load_sel = 1'b0; sp_load_val = 32'h0000_1000;
      @(negedge clk);
      sp_load_sel = 1'b1; sp_load_val = 32'h0000_8000;
      @(negedge clk);
      sp_load = 1'b0;
      chk(live_sp == 32'h1000, "R11", "live load", live_sp, 32'h1000);
      chk(shadow_sp == 32'h8000, "R11", "shadow load", shadow_sp, 32'h8000);
      m_live = 32'h1000;
      m_shadow = 32'h8000;

      for (int i = 0; i < NV; i++) begin
         logic [2:0]  e_opc;
         logic [15:0] e_word;
         logic [7:0]  e_cost;
         logic [4:0]  e_fl;
         logic [4:0]  got_fl;
         string       tg;
         e_opc  = VEC[i][51:49];
         e_word = VEC[i][28:13];
         e_cost = VEC[i][12:5];
         e_fl   = VEC[i][4:0];
         tg     = tag_of(e_opc, e_fl);
         op_valid   = 1'b1;
         op_code    = e_opc;
         op_fn      = VEC[i][48:47];
         cpu_super  = VEC[i][46];
         rd_to_mem  = VEC[i][45];
         op_operand = VEC[i][44:29];
         @(negedge clk);
         op_valid = 1'b0;
         if (e_fl[2]) begin
            logic [SP_W-1:0] t;
            t = m_live; m_live = m_shadow; m_shadow = t;
         end
         got_fl = {op_illegal, priv_fault, sp_swap, irq_recheck, trace_recheck};
         chk(status_word == e_word, tg, $sformatf("row %0d word", i), 32'(status_word), 32'(e_word));
         chk(op_cost == e_cost, tg, $sformatf("row %0d cost", i), 32'(op_cost), 32'(e_cost));
         chk(got_fl == e_fl, "R8 R9", $sformatf("row %0d pulses", i), 32'(got_fl), 32'(e_fl));
         chk(op_done, "R12", $sformatf("row %0d done", i), 32'(op_done), 1);
         chk(live_sp == m_live && shadow_sp == m_shadow, "R9", $sformatf("row %0d live pointer", i),
             live_sp, m_live);
         if (e_opc == 3'd0)
            chk(rd_data == e_word, "R2", $sformatf("row %0d read data", i), 32'(rd_data), 32'(e_word));
         if (e_fl[3])
            chk(fault_vector == 8'd8, "R4", $sformatf("row %0d vector", i), 32'(fault_vector), 8);
         if (i == 9)
            chk(status_nt == 16'h031B, "R7", "no-trace mask after XOR", 32'(status_nt), 32'h031B);
         if (i == 12)
            chk(status_nt == 16'h271F, "R3", "no-trace mask after load", 32'(status_nt), 32'h271F);
      end

      // R12: no strobe, no done
      @(negedge clk);
      chk(!op_done, "R12", "done after idle", 32'(op_done), 0);

      // R11: load ignored while a strobe is present (read op)
      sp_load = 1'b1; sp_load_sel = 1'b0; sp_load_val = 32'hDEAD_BEEF;
      op_valid = 1'b1; op_code = 3'd0; rd_to_mem = 1'b0;
      @(negedge clk);
      op_valid = 1'b0; sp_load = 1'b0;
      chk(live_sp == m_live, "R11", "load during strobe", live_sp, m_live);
      chk(rd_data == 16'h0000, "R2", "read of cleared word", 32'(rd_data), 0);

      // R1: reset again
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(status_word == 16'h2000, "R1", "word after second reset", 32'(status_word), 32'h2000);
      chk(live_sp == '0, "R1", "pointer after second reset", live_sp, 0);

      finish_run();
   end

endmodule